// File: doc/BRIEF.md
# Guarded Two-Channel AVS Default Setpoint Register

This block stores the power-up setpoint for an adaptive voltage scaling reference, one 10-bit value for each output channel. Each channel has its own page. One count is 2 mV. A register-bus style port carries writes with a page select, a 16-bit data word and a write kind. The write kind is either a host write or a restore from nonvolatile storage. A separate read page select returns the chosen page, zero-extended to 16 bits. Both stored values also leave the block on a flattened bus, so the rest of the controller can use them.

Every write is checked before it is stored. Two things can block a write: the current operating mode, and an upper and lower clamp supplied from outside. A rejected host write is still acknowledged, but it leaves a sticky status flag behind. The alert output is the OR of those flags. A restore attempted while the reference is locked is dropped silently. The flags stay set until a clear pulse arrives.

Top module: `avs_dflt_regbank`

## Requirements
- R1: After reset both pages hold 500 (0x01F4). The flags `flag_other`, `flag_invalid` and `flag_cml` are low, and `alert` is low.
- R2: `rd_data` equals the 10-bit value of the page on `rd_page`, with bits 15:10 reading zero. Bits 15:10 of `wr_data` are ignored: only `wr_data[9:0]` is checked and stored.
- R3: A write is accepted when `op_mode` is 00 (normal) or 01 (startup) and the field lies within `clamp_lo`..`clamp_hi` inclusive. An accepted write updates only the page on `wr_page`. The new value is visible right after the clock edge that samples `wr_en`. Page p occupies bits [10p+9:10p] of `setpt_all`.
- R4: A host write (`wr_kind`=0) while `op_mode` is 10 (locked) or 11 (treated as locked) leaves both pages unchanged. It sets `flag_other` and raises `alert`.
- R5: A restore (`wr_kind`=1) while `op_mode` is locked leaves both pages unchanged and sets no flag.
- R6: In an unlocked mode, a write of either kind whose field is above `clamp_hi` or below `clamp_lo` is not stored. It sets `flag_invalid` and `flag_cml`, and raises `alert`.
- R7: The mode check comes before the clamp check. A locked-mode host write with an out-of-range field sets only `flag_other`.
- R8: The flags are sticky. `clr_faults` clears all of them. A flag being set in the same cycle as `clr_faults` stays set. `alert` is high exactly while any flag is high.
- R9: `wr_ack` is high for one cycle, in the cycle after each `wr_en` strobe, whether the write was accepted or rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_page | input | 1 | Page selected by the write |
| wr_data | input | 16 | Write word; only bits 9:0 are used |
| wr_kind | input | 1 | 0 = host write, 1 = restore from nonvolatile storage |
| rd_page | input | 1 | Page shown on `rd_data` |
| rd_data | output | 16 | Zero-extended value of the selected page |
| op_mode | input | 2 | 00 normal, 01 startup, 10 locked, 11 locked |
| clamp_hi | input | 10 | Highest value a write may store |
| clamp_lo | input | 10 | Lowest value a write may store |
| clr_faults | input | 1 | Pulse that clears the sticky flags |
| wr_ack | output | 1 | Acknowledge, one cycle after each strobe |
| flag_other | output | 1 | Sticky: a host write was refused by the mode |
| flag_invalid | output | 1 | Sticky: the write data was outside the clamps |
| flag_cml | output | 1 | Sticky summary communication flag |
| alert | output | 1 | OR of the sticky flags |
| setpt_all | output | 20 | Both page values, page 0 in the low bits |

## Verification
The hardest case to reach is the overlap of rejection causes. One such case is a locked-mode host write whose field is also outside the clamps. Another is a flag being set in the same cycle that `clr_faults` is pulsed. The bench reaches both by sweeping every mode against every write kind, both pages and a set of fields that straddle each clamp edge. The clear pulse is aimed at the same edge as a rejected write. A further sweep writes every 10-bit field value against a narrowed clamp window, and a reference model in the bench tracks the expected contents of both pages and all flags.

// File: rtl/avsd_pkg.sv
package avsd_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_STARTUP = 2'b01,
    MODE_LOCKED  = 2'b10,
    MODE_RSVD    = 2'b11
  } op_mode_e;

  typedef enum logic {
    WK_HOST    = 1'b0,
    WK_RESTORE = 1'b1
  } wr_kind_e;

  // Both upper encodings freeze the stored setpoints.
  function automatic logic mode_locked(input op_mode_e m);
    return (m == MODE_LOCKED) || (m == MODE_RSVD);
  endfunction

endpackage

// File: rtl/avsd_write_guard.sv
module avsd_write_guard
  import avsd_pkg::*;
#(
  parameter int FIELD_W = 10
) (
  input  logic               wr_en,
  input  logic               wr_kind,
  input  logic [1:0]         op_mode,
  input  logic [FIELD_W-1:0] field,
  input  logic [FIELD_W-1:0] clamp_hi,
  input  logic [FIELD_W-1:0] clamp_lo,
  output logic               commit,
  output logic               set_other,
  output logic               set_invalid
);

  logic locked;
  logic out_of_range;
  logic is_host;

  always_comb begin
    locked       = mode_locked(op_mode_e'(op_mode));
    out_of_range = (field > clamp_hi) || (field < clamp_lo);
    is_host      = (wr_kind_e'(wr_kind) == WK_HOST);
    commit      = 1'b0;
    set_other   = 1'b0;
    set_invalid = 1'b0;
    if (wr_en) begin
      if (locked) begin
        // Mode gating first; restores are dropped silently.
        set_other = is_host;
      end else if (out_of_range) begin
        set_invalid = 1'b1;
      end else begin
        commit = 1'b1;
      end
    end
  end

  // R7: at most one rejection cause is reported per write.
  always_comb begin
    a_r7_single_cause: assert (!(set_other && set_invalid));
  end

endmodule

// File: rtl/avsd_page_bank.sv
module avsd_page_bank #(
  parameter int          FIELD_W   = 10,
  parameter logic [15:0] RESET_VAL = 16'h01F4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [FIELD_W-1:0] d,
  output logic [FIELD_W-1:0] q
);

  logic [FIELD_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_VAL[FIELD_W-1:0];
    else        q <= q_nxt;
  end

  // R3: a load lands in the same edge that sees the enable.
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(d)));

  // R4: without an enable the page holds its value.
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

endmodule

// File: rtl/avsd_fault_flags.sv
module avsd_fault_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_other,
  input  logic set_invalid,
  input  logic clr,
  output logic flag_other,
  output logic flag_invalid,
  output logic flag_cml,
  output logic alert
);

  logic oth_nxt, ivd_nxt, cml_nxt;

  always_comb begin
    oth_nxt = flag_other;
    ivd_nxt = flag_invalid;
    cml_nxt = flag_cml;
    if (clr) begin
      oth_nxt = 1'b0;
      ivd_nxt = 1'b0;
      cml_nxt = 1'b0;
    end
    // A new cause in the clearing cycle survives the clear.
    if (set_other)   oth_nxt = 1'b1;
    if (set_invalid) begin
      ivd_nxt = 1'b1;
      cml_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_other   <= 1'b0;
      flag_invalid <= 1'b0;
      flag_cml     <= 1'b0;
    end else begin
      flag_other   <= oth_nxt;
      flag_invalid <= ivd_nxt;
      flag_cml     <= cml_nxt;
    end
  end

  assign alert = flag_other | flag_invalid | flag_cml;

  // R8: a clear with no new cause leaves the alert low.
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_other && !set_invalid) |=> !alert);

  // R8: flags persist without a clear.
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && alert) |=> alert);

  // R6: an invalid-data cause raises the summary flag too.
  a_r6_cml: assert property (@(posedge clk) disable iff (!rst_n)
    set_invalid |=> (flag_invalid && flag_cml));

endmodule

// File: rtl/avs_dflt_regbank.sv
module avs_dflt_regbank
  import avsd_pkg::*;
#(
  parameter int          NUM_PAGES = 2,
  parameter int          FIELD_W   = 10,
  parameter int          WORD_W    = 16,
  parameter logic [15:0] RESET_VAL = 16'h01F4,
  localparam int         PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int         PAD_W     = WORD_W - FIELD_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [PAGE_W-1:0]            wr_page,
  input  logic [WORD_W-1:0]            wr_data,
  input  logic                         wr_kind,
  input  logic [PAGE_W-1:0]            rd_page,
  output logic [WORD_W-1:0]            rd_data,
  input  logic [1:0]                   op_mode,
  input  logic [FIELD_W-1:0]           clamp_hi,
  input  logic [FIELD_W-1:0]           clamp_lo,
  input  logic                         clr_faults,
  output logic                         wr_ack,
  output logic                         flag_other,
  output logic                         flag_invalid,
  output logic                         flag_cml,
  output logic                         alert,
  output logic [NUM_PAGES*FIELD_W-1:0] setpt_all
);

  logic               commit;
  logic               set_other;
  logic               set_invalid;
  logic [FIELD_W-1:0] wr_field;
  logic               ack_nxt;

  assign wr_field = wr_data[FIELD_W-1:0];

  avsd_write_guard #(.FIELD_W(FIELD_W)) guard_i (
    .wr_en       (wr_en),
    .wr_kind     (wr_kind),
    .op_mode     (op_mode),
    .field       (wr_field),
    .clamp_hi    (clamp_hi),
    .clamp_lo    (clamp_lo),
    .commit      (commit),
    .set_other   (set_other),
    .set_invalid (set_invalid)
  );

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    logic page_we;
    assign page_we = commit && (wr_page == PAGE_W'(p));
    avsd_page_bank #(.FIELD_W(FIELD_W), .RESET_VAL(RESET_VAL)) bank_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (page_we),
      .d     (wr_field),
      .q     (setpt_all[p*FIELD_W +: FIELD_W])
    );
  end

  avsd_fault_flags flags_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_other    (set_other),
    .set_invalid  (set_invalid),
    .clr          (clr_faults),
    .flag_other   (flag_other),
    .flag_invalid (flag_invalid),
    .flag_cml     (flag_cml),
    .alert        (alert)
  );

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NUM_PAGES; p++) begin
      if (rd_page == PAGE_W'(p))
        rd_data = {{PAD_W{1'b0}}, setpt_all[p*FIELD_W +: FIELD_W]};
    end
  end

  assign ack_nxt = wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ack <= 1'b0;
    else        wr_ack <= ack_nxt;
  end

  // R4: a locked-mode write of any kind freezes all pages.
  a_r4_locked_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_mode[1]) |=> $stable(setpt_all));

  // R5: a locked-mode restore never raises the other flag.
  a_r5_restore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind && op_mode[1] && !flag_other) |=> !flag_other);

  // R6: out-of-clamp data is never stored.
  a_r6_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_field > clamp_hi || wr_field < clamp_lo)) |=> $stable(setpt_all));

  // R9: every strobe is acknowledged on the next cycle.
  a_r9_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> wr_ack);

endmodule

// File: tb/avs_dflt_regbank_tb_top.sv
module avs_dflt_regbank_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic        wr_page;
  logic [15:0] wr_data;
  logic        wr_kind;
  logic        rd_page;
  logic [15:0] rd_data;
  logic [1:0]  op_mode;
  logic [9:0]  clamp_hi;
  logic [9:0]  clamp_lo;
  logic        clr_faults;
  logic        wr_ack;
  logic        flag_other, flag_invalid, flag_cml, alert;
  logic [19:0] setpt_all;

  int n_vec  = 0;
  int n_fail = 0;
  int m_val [2];
  bit m_oth, m_ivd, m_cml;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  avs_dflt_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_page(wr_page),
    .wr_data(wr_data), .wr_kind(wr_kind), .rd_page(rd_page),
    .rd_data(rd_data), .op_mode(op_mode), .clamp_hi(clamp_hi),
    .clamp_lo(clamp_lo), .clr_faults(clr_faults), .wr_ack(wr_ack),
    .flag_other(flag_other), .flag_invalid(flag_invalid),
    .flag_cml(flag_cml), .alert(alert), .setpt_all(setpt_all)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compares every port-visible state against the model (R1 R2 R3 R8).
  task automatic check_state(input string req);
    for (int p = 0; p < 2; p++) begin
      rd_page = p[0];
      #1;
      chk({req, " rd_data"}, int'(rd_data), m_val[p]);
      chk({req, " setpt_all"}, int'(setpt_all[p*10 +: 10]), m_val[p]);
    end
    chk({req, " flag_other"}, int'(flag_other), int'(m_oth));
    chk({req, " flag_invalid"}, int'(flag_invalid), int'(m_ivd));
    chk({req, " flag_cml"}, int'(flag_cml), int'(m_cml));
    chk({req, " R8 alert"}, int'(alert), int'(m_oth | m_ivd | m_cml));
  endtask

  task automatic do_write(input bit pg, input logic [15:0] d, input bit kind,
                          input bit with_clr, input string req);
    int f;
    bit locked;
    @(negedge clk);
    wr_en = 1'b1; wr_page = pg; wr_data = d; wr_kind = kind;
    clr_faults = with_clr;
    f = int'(d[9:0]);
    locked = op_mode[1];
    if (with_clr) begin m_oth = 0; m_ivd = 0; m_cml = 0; end
    if (locked) begin
      if (!kind) m_oth = 1;                         // R4, R5, R7
    end else if (f > int'(clamp_hi) || f < int'(clamp_lo)) begin
      m_ivd = 1; m_cml = 1;                         // R6
    end else begin
      m_val[pg] = f;                                // R2 R3
    end
    @(negedge clk);
    chk({req, " R9 ack"}, int'(wr_ack), 1);
    wr_en = 1'b0; clr_faults = 1'b0;
    wr_data = 16'hFFFF;
    check_state(req);
    @(negedge clk);
    chk({req, " R9 ack pulse"}, int'(wr_ack), 0);
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_faults = 1'b1;
    @(negedge clk);
    clr_faults = 1'b0;
    m_oth = 0; m_ivd = 0; m_cml = 0;
    check_state("R8 clear");
  endtask

  initial begin
    logic [15:0] pats [10];
    pats = '{16'd0, 16'd249, 16'd250, 16'd251, 16'd500,
             16'd749, 16'd750, 16'd751, 16'd1023, 16'hFC00 | 16'd600};
    rst_n = 1'b0; wr_en = 1'b0; wr_page = 1'b0; wr_data = '0; wr_kind = 1'b0;
    rd_page = 1'b0; op_mode = 2'b00; clamp_hi = 10'd750; clamp_lo = 10'd250;
    clr_faults = 1'b0;
    m_val[0] = 500; m_val[1] = 500; m_oth = 0; m_ivd = 0; m_cml = 0;
    repeat (3) @(negedge clk);
    check_state("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 after release");
    chk("R1 wr_ack", int'(wr_ack), 0);

    // Mode x kind x page x boundary data sweep (R3 R4 R5 R6 R7).
    for (int m = 0; m < 4; m++) begin
      op_mode = m[1:0];
      for (int k = 0; k < 2; k++)
        for (int pg = 0; pg < 2; pg++)
          for (int i = 0; i < 10; i++) begin
            do_write(pg[0], pats[i], k[0], 1'b0, "R3-R7 sweep");
            if (alert) clear_all();
          end
    end

    // R2: upper bits ignored on an accepted write.
    op_mode = 2'b01;
    do_write(1'b0, 16'hA800 | 16'd333, 1'b0, 1'b0, "R2 upper ignored");
    chk("R2 page0 333", int'(setpt_all[9:0]), 333);

    // R7: locked host write out of range sets only other.
    op_mode = 2'b10;
    do_write(1'b1, 16'd900, 1'b0, 1'b0, "R7 priority");
    chk("R7 invalid low", int'(flag_invalid), 0);

    // R8: stickiness across idle cycles, then set-wins on a clear edge.
    repeat (5) @(negedge clk);
    chk("R8 sticky", int'(flag_other), 1);
    op_mode = 2'b00;
    do_write(1'b0, 16'd100, 1'b0, 1'b1, "R8 set beats clear");
    chk("R8 other cleared", int'(flag_other), 0);
    chk("R8 invalid kept", int'(flag_invalid), 1);
    clear_all();

    // Exhaustive field sweep against a narrowed window (R3 R6).
    clamp_lo = 10'd300; clamp_hi = 10'd700;
    for (int v = 0; v < 1024; v++) begin
      op_mode = v[0] ? 2'b01 : 2'b00;
      do_write(v[1], 16'(v), v[2], 1'b0, "R3 R6 field sweep");
      if (alert) clear_all();
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule